// File: doc/BRIEF.md
# Multi-Line Averaging Fine-Time Encoder

This block turns the captured states of several parallel tapped delay lines into one fine timestamp per hit. Every line is sampled on the same clock edge after the same hit. Neighbouring lines are staggered by a fixed delay, so their readings differ by a known amount. Each line's tap vector is reduced to a bin count by counting its set taps, so isolated bubbles in the thermometer pattern do not change the result. A per-line offset is subtracted, and the corrected counts are summed.

The sum is the fine time. Read as a fixed-point number, its low log2(NLINES) bits are the fraction, so the value is the average of the line readings at a resolution finer than one cell. The block never divides. A free-running coarse counter is captured on the hit strobe and placed above the fine field. A single error bit reports any line whose vector was empty or completely full. One hit can be accepted on every clock, and each result appears a fixed three cycles after its strobe.

Top module: `tdc_avg_enc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid`, `out_err` and `out_time` are all zero, and the coarse counter restarts from 0.
- R2: A strobe that is high in cycle n gives `out_valid` high in cycle n+3 and in no other cycle. Strobes in consecutive cycles give results in consecutive cycles, in the same order.
- R3: The reading of each line is the number of ones in its TAPS-bit slice `taps[i*TAPS +: TAPS]`, wherever those ones sit, so a bubble that moves a one does not change the result.
- R4: Before summing, line i has the unsigned value in `line_ofs[i*CW +: CW]` subtracted from its reading, with CW = clog2(TAPS+1).
- R5: `out_time[FW-1:0]` holds the two's-complement sum of all corrected readings, with FW = CW+1+log2(NLINES). Its low log2(NLINES) bits are the fractional part of the average.
- R6: `out_time[FW +: CRS_W]` holds the value of the coarse counter during the strobe cycle. The counter is 0 in the first cycle after reset, increments by one every clock and wraps.
- R7: `out_err` is 1 for a hit when at least one line reads 0 ones or TAPS ones, and 0 otherwise.
- R8: While `out_valid` is low, `out_time` and `out_err` keep their last values, and tap activity without a strobe produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_strb | input | 1 | High in a cycle whose tap vectors hold a hit |
| taps | input | NLINES*TAPS | Captured tap vectors, with line i at bits [i*TAPS +: TAPS] |
| line_ofs | input | NLINES*CW | Per-line offset constants, with line i at bits [i*CW +: CW] |
| out_valid | output | 1 | Result strobe, high three cycles after `hit_strb` |
| out_time | output | CRS_W+FW | Coarse count above the signed fine sum |
| out_err | output | 1 | At least one line was empty or saturated |

## Verification
The bench drives thermometer patterns with bubbles placed next to the edge. A decoder that searched for the edge instead of counting ones would give a different bin for these. Offsets larger than the readings force a negative sum, which exposes a design that treats the sum as unsigned or loses the sign extension. Lines that are completely empty or completely full check the error bit at both ends of the range. A decoder that flagged only one end would miss the other. Three hits in consecutive cycles and a run of tap changes without a strobe check the pipeline: results must come out in order at the right cycles, and a design that loaded its registers whenever the taps moved would corrupt the held output.

// File: rtl/tdc_avg_pkg.sv
package tdc_avg_pkg;

    localparam int DEF_LINES  = 8;
    localparam int DEF_TAPS   = 32;
    localparam int DEF_CRS_W  = 16;

    // range status of one delay line reading
    typedef enum logic [1:0] {
        RNG_OK    = 2'd0,
        RNG_EMPTY = 2'd1,
        RNG_FULL  = 2'd2
    } rng_e;

    function automatic rng_e classify(input int cnt, input int taps);
        if (cnt == 0)
            return RNG_EMPTY;
        else if (cnt == taps)
            return RNG_FULL;
        else
            return RNG_OK;
    endfunction

endpackage

// File: rtl/tdc_line_cnt.sv
module tdc_line_cnt
    import tdc_avg_pkg::*;
#(
    parameter int TAPS = DEF_TAPS,
    localparam int CW  = $clog2(TAPS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [TAPS-1:0] taps,
    output logic [CW-1:0]   cnt_q,
    output rng_e            rng_q
);

    logic [CW-1:0] cnt_d;

    // ones count: bubble tolerant, independent of where the ones sit
    always_comb begin
        cnt_d = '0;
        for (int b = 0; b < TAPS; b++)
            cnt_d = cnt_d + CW'(taps[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rng_q <= RNG_OK;
        end else if (ld) begin
            cnt_q <= cnt_d;
            rng_q <= classify(int'(cnt_d), TAPS);
        end
    end

endmodule

// File: rtl/tdc_avg_sum.sv
module tdc_avg_sum #(
    parameter int NLINES = 8,
    parameter int CW     = 6,
    parameter int CRS_W  = 16,
    localparam int LGM   = $clog2(NLINES),
    localparam int FW    = CW + 1 + LGM
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v1,
    input  logic [NLINES*CW-1:0] cnt_flat,
    input  logic [NLINES*CW-1:0] ofs_flat,
    input  logic                 err1,
    input  logic [CRS_W-1:0]     crs1,
    output logic                 v3,
    output logic [FW-1:0]        fine3,
    output logic                 err3,
    output logic [CRS_W-1:0]     crs3
);

    // stage 2: per-line stagger correction
    logic signed [CW:0] corr_q [NLINES];
    logic               v2;
    logic               err2;
    logic [CRS_W-1:0]   crs2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v2   <= 1'b0;
            err2 <= 1'b0;
            crs2 <= '0;
            for (int i = 0; i < NLINES; i++)
                corr_q[i] <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                err2 <= err1;
                crs2 <= crs1;
                for (int i = 0; i < NLINES; i++)
                    corr_q[i] <= $signed({1'b0, cnt_flat[i*CW +: CW]})
                               - $signed({1'b0, ofs_flat[i*CW +: CW]});
            end
        end
    end

    // stage 3: full-precision sum, read as fixed point with LGM fraction bits
    logic signed [FW-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int i = 0; i < NLINES; i++)
            sum_d = sum_d + {{(FW-CW-1){corr_q[i][CW]}}, corr_q[i]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v3    <= 1'b0;
            fine3 <= '0;
            err3  <= 1'b0;
            crs3  <= '0;
        end else begin
            v3 <= v2;
            if (v2) begin
                fine3 <= sum_d;
                err3  <= err2;
                crs3  <= crs2;
            end
        end
    end

endmodule

// File: rtl/tdc_avg_enc.sv
module tdc_avg_enc
    import tdc_avg_pkg::*;
#(
    parameter int NLINES = DEF_LINES,
    parameter int TAPS   = DEF_TAPS,
    parameter int CRS_W  = DEF_CRS_W,
    localparam int CW    = $clog2(TAPS + 1),
    localparam int LGM   = $clog2(NLINES),
    localparam int FW    = CW + 1 + LGM
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit_strb,
    input  logic [NLINES*TAPS-1:0] taps,
    input  logic [NLINES*CW-1:0]   line_ofs,
    output logic                   out_valid,
    output logic [CRS_W+FW-1:0]    out_time,
    output logic                   out_err
);

    logic [CRS_W-1:0]     crs_q;
    logic [CRS_W-1:0]     crs1;
    logic                 v1;
    logic [NLINES*CW-1:0] cnt_flat;
    rng_e                 rng_q [NLINES];
    logic                 err1;
    logic [FW-1:0]        fine3;
    logic [CRS_W-1:0]     crs3;

    // free-running coarse counter
    always_ff @(posedge clk) begin
        if (rst)
            crs_q <= '0;
        else
            crs_q <= crs_q + 1'b1;
    end

    // stage 1: capture valid and coarse time with the per-line counts
    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            crs1 <= '0;
        end else begin
            v1 <= hit_strb;
            if (hit_strb)
                crs1 <= crs_q;
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        tdc_line_cnt #(.TAPS(TAPS)) u_line (
            .clk   (clk),
            .rst   (rst),
            .ld    (hit_strb),
            .taps  (taps[g*TAPS +: TAPS]),
            .cnt_q (cnt_flat[g*CW +: CW]),
            .rng_q (rng_q[g])
        );
    end

    always_comb begin
        err1 = 1'b0;
        for (int i = 0; i < NLINES; i++)
            if (rng_q[i] != RNG_OK)
                err1 = 1'b1;
    end

    tdc_avg_sum #(.NLINES(NLINES), .CW(CW), .CRS_W(CRS_W)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .v1       (v1),
        .cnt_flat (cnt_flat),
        .ofs_flat (line_ofs),
        .err1     (err1),
        .crs1     (crs1),
        .v3       (out_valid),
        .fine3    (fine3),
        .err3     (out_err),
        .crs3     (crs3)
    );

    assign out_time = {crs3, fine3};

endmodule

// File: rtl/tdc_avg_enc_chk.sv
module tdc_avg_enc_chk #(
    parameter int NLINES = 8,
    parameter int TAPS   = 32,
    parameter int CRS_W  = 16,
    localparam int CW    = $clog2(TAPS + 1),
    localparam int FW    = CW + 1 + $clog2(NLINES)
) (
    input logic                clk,
    input logic                rst,
    input logic                hit_strb,
    input logic                out_valid,
    input logic [CRS_W-1:0]    crs_q,
    input logic [CRS_W+FW-1:0] out_time,
    input logic                out_err
);

    // R1: outputs idle in the first cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R2: every strobe yields a result exactly three cycles later
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        hit_strb |-> ##3 out_valid);

    // R2: no result without a strobe three cycles earlier
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(hit_strb, 3));

    // R6: coarse counter advances by one each clock
    a_r6_coarse_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> crs_q == CRS_W'($past(crs_q) + 1'b1));

    // R8: outputs held between results
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_time) && $stable(out_err)));

endmodule

bind tdc_avg_enc tdc_avg_enc_chk #(
    .NLINES (NLINES),
    .TAPS   (TAPS),
    .CRS_W  (CRS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hit_strb  (hit_strb),
    .out_valid (out_valid),
    .crs_q     (crs_q),
    .out_time  (out_time),
    .out_err   (out_err)
);

// File: tb/sim_tdc_avg_enc.sv
module sim_tdc_avg_enc;

    localparam int NL  = 8;
    localparam int TP  = 32;
    localparam int CRS = 16;
    localparam int CW  = $clog2(TP + 1);
    localparam int FW  = CW + 1 + $clog2(NL);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               hit_strb = 1'b0;
    logic [NL*TP-1:0]   taps = '0;
    logic [NL*CW-1:0]   line_ofs = '0;
    logic               out_valid;
    logic [CRS+FW-1:0]  out_time;
    logic               out_err;

    int errors = 0;
    int checks = 0;
    logic [CRS-1:0] mc = '0;

    always #10 clk = ~clk;

    // bench copy of the coarse counter as specified in R6
    always @(posedge clk) begin
        if (rst) mc <= '0;
        else     mc <= mc + 1'b1;
    end

    tdc_avg_enc #(.NLINES(NL), .TAPS(TP), .CRS_W(CRS)) u0 (
        .clk       (clk),
        .rst       (rst),
        .hit_strb  (hit_strb),
        .taps      (taps),
        .line_ofs  (line_ofs),
        .out_valid (out_valid),
        .out_time  (out_time),
        .out_err   (out_err)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [TP-1:0] therm(input int k);
        logic [TP:0] one = 1;
        return TP'((one << k) - 1);
    endfunction

    // same count as therm(k), with one set tap moved just above the edge
    function automatic logic [TP-1:0] bubbled(input int k);
        logic [TP-1:0] v = therm(k);
        v[k-2] = 1'b0;
        v[k]   = 1'b1;
        return v;
    endfunction

    function automatic logic [FW-1:0] exp_fine(input logic [NL*TP-1:0] t,
                                               input logic [NL*CW-1:0] o);
        int s = 0;
        for (int i = 0; i < NL; i++)
            s += $countones(t[i*TP +: TP]) - int'(o[i*CW +: CW]);
        return FW'(s);
    endfunction

    function automatic logic exp_err(input logic [NL*TP-1:0] t);
        logic e = 1'b0;
        for (int i = 0; i < NL; i++) begin
            int c = $countones(t[i*TP +: TP]);
            if (c == 0 || c == TP) e = 1'b1;
        end
        return e;
    endfunction

    // one hit, checked at its three-cycle latency point
    task automatic single_hit(input string req, input logic [NL*TP-1:0] t,
                              input logic [NL*CW-1:0] o);
        logic [CRS-1:0] ec;
        @(negedge clk);
        taps = t; line_ofs = o; hit_strb = 1'b1;
        ec = mc;
        @(negedge clk);
        hit_strb = 1'b0;
        @(negedge clk);
        chk("R2", "valid before latency", out_valid, 0);
        @(negedge clk);
        chk("R2", "valid at latency", out_valid, 1);
        chk(req, "fine sum", out_time[FW-1:0], exp_fine(t, o));
        chk("R6", "coarse field", out_time[FW +: CRS], ec);
        chk("R7", "error bit", out_err, exp_err(t));
        @(negedge clk);
        chk("R2", "valid after latency", out_valid, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1", "valid in reset", out_valid, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", out_valid, 0);
        chk("R1", "time after reset", out_time, 0);
        chk("R1", "err after reset", out_err, 0);
        chk("R1", "coarse model restart", mc, 1);
    endtask

    task automatic test_plain();
        logic [NL*TP-1:0] t;
        for (int i = 0; i < NL; i++) t[i*TP +: TP] = therm(10 + i);
        single_hit("R5", t, '0);           // 108
    endtask

    task automatic test_bubbles();
        logic [NL*TP-1:0] t;
        for (int i = 0; i < NL; i++) t[i*TP +: TP] = bubbled(10 + i);
        single_hit("R3", t, '0);           // still 108
    endtask

    task automatic test_offsets();
        logic [NL*TP-1:0] t;
        logic [NL*CW-1:0] o;
        for (int i = 0; i < NL; i++) begin
            t[i*TP +: TP] = therm(10 + i);
            o[i*CW +: CW] = CW'(i);
        end
        single_hit("R4", t, o);            // 108 - 28 = 80
        for (int i = 0; i < NL; i++) begin
            t[i*TP +: TP] = therm(1);
            o[i*CW +: CW] = CW'(5);
        end
        single_hit("R5", t, o);            // 8 * (1 - 5) = -32
    endtask

    task automatic test_range();
        logic [NL*TP-1:0] t;
        for (int i = 0; i < NL; i++) t[i*TP +: TP] = therm(16);
        t[3*TP +: TP] = '0;
        single_hit("R7", t, '0);           // empty line
        for (int i = 0; i < NL; i++) t[i*TP +: TP] = therm(16);
        t[6*TP +: TP] = '1;
        single_hit("R7", t, '0);           // saturated line
        for (int i = 0; i < NL; i++) t[i*TP +: TP] = therm(i == 0 ? 1 : TP - 1);
        single_hit("R7", t, '0);           // extremes just inside range
    endtask

    task automatic test_back_to_back();
        logic [NL*TP-1:0] t [3];
        logic [CRS-1:0]   ec [3];
        for (int h = 0; h < 3; h++)
            for (int i = 0; i < NL; i++)
                t[h][i*TP +: TP] = therm(4 + 7*h + i);
        line_ofs = '0;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            taps = t[h]; hit_strb = 1'b1; ec[h] = mc;
        end
        @(negedge clk);
        hit_strb = 1'b0;
        for (int h = 0; h < 3; h++) begin
            if (h > 0) @(negedge clk);
            chk("R2", "burst valid", out_valid, 1);
            chk("R2", "burst order fine", out_time[FW-1:0], exp_fine(t[h], '0));
            chk("R6", "burst coarse", out_time[FW +: CRS], ec[h]);
        end
        @(negedge clk);
        chk("R2", "burst end", out_valid, 0);
    endtask

    task automatic test_ignore();
        logic [CRS+FW-1:0] held_t = out_time;
        logic              held_e = out_err;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            taps = {NL{therm(3 + 4*k)}};
            chk("R8", "no valid without strobe", out_valid, 0);
            chk("R8", "time held", out_time, held_t);
            chk("R8", "err held", out_err, held_e);
        end
        repeat (3) @(negedge clk);
        chk("R8", "time held after idle taps", out_time, held_t);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        test_reset();
        test_plain();
        test_bubbles();
        test_offsets();
        test_range();
        test_back_to_back();
        test_ignore();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule